// File: doc/BRIEF.md
# Fractional-N Division Ratio Controller

This block chooses, for every feedback cycle of a multi-modulus divider, whether that cycle divides by the integer part N or by N+1. Over a long run, the average ratio settles at N + F/M. The clock is the divided feedback edge, and each rising edge counts as one tick. The block keeps an accumulator that wraps at a programmable modulus M. M is any value from 1 to 4095, not only a power of two. This means channel steps such as a reference divided by 65, 130 or 520 come out exactly. For example, N = 138, F = 30, M = 65 gives an average of about 138.46.

A load strobe writes the three programming values into a holding stage. On the following tick they become active together, and the accumulator restarts at that moment. The restart value is zero, unless dithering is requested. With dithering, the restart value is a pseudo-random word from a free-running 12-bit LFSR, reduced modulo M. A fraction that is not below the modulus is clamped and reported on an error flag.

Top module: `fracn_ratio_ctrl`

## Requirements
- R1: After reset, `divRatio` is 0 and `fracErr` is 0.
- R2: On every tick, `divRatio` equals the active N or N+1, and the internal accumulator stays below the active M.
- R3: After a load, any window of exactly M consecutive step ticks yields a `divRatio` sum of M·N + F. This holds with dithering on or off.
- R4: With dithering off, step tick k (counting from 1 after the apply tick) outputs N+1 exactly when floor(k·F/M) > floor((k−1)·F/M). The pattern is fully deterministic and repeats every M ticks.
- R5: Values present at an edge where `loadStb` is 1 are captured. At the next edge they become active, and that edge outputs the new N with no step. Changes to `intIn`, `fracIn`, `modIn` or `ditherEn` without the strobe have no effect.
- R6: If `fracIn` ≥ `modIn` at capture, F is clamped to M−1. `fracErr` goes to 1 at the capture edge and holds until a later capture with valid values clears it.
- R7: A `modIn` of 0 is treated as M = 1 with F = 0, and it sets `fracErr`.
- R8: When strobes arrive on two consecutive edges, the second edge applies the first set and captures the second set. The third edge applies the second set.
- R9: With `ditherEn` = 1 at capture, the accumulator restarts at an LFSR-derived value below M. R2 and R3 still hold.
- R10: With F = 0, every tick outputs exactly N.
- R11: Any modulus from 1 to 4095 is honoured, including non-binary values such as 65, 520 and 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divided feedback edge, used as the tick clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadStb | input | 1 | Captures the programming values at this edge |
| intIn | input | 16 | Integer part N |
| fracIn | input | 12 | Fractional numerator F |
| modIn | input | 12 | Modulus M |
| ditherEn | input | 1 | Selects a pseudo-random accumulator restart value |
| divRatio | output | 17 | Division ratio for the current cycle |
| fracErr | output | 1 | The last captured F or M was invalid |

## Verification
A new load can be captured on the same edge that applies the previous one. The collision case, R8, is provoked by strobing on two edges in a row with different random settings. The bench then judges the result by the output on each of the two following edges: first the first set's N, then the second set's N. After that, the bench checks the second set's complete M-tick pattern and sum. This confirms that the overlap neither lost nor mixed any field. The bench also checks the error flag after each capture, including captures that overlap an apply.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  // Strobes from control to datapath; exactly one is active per tick
  typedef struct packed {
    logic applyNew;  // load the pending set, restart accumulator
    logic stepAcc;   // normal accumulate-and-compare tick
  } fnStrobe_t;
endpackage

// File: rtl/fracn_ctrl.sv
module fracn_ctrl
  import fracn_pkg::*;
#(
  parameter int INT_W = 16,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStb,
  input  logic [INT_W-1:0] intIn,
  input  logic [MOD_W-1:0] fracIn,
  input  logic [MOD_W-1:0] modIn,
  input  logic             ditherEn,
  output fnStrobe_t        strobe,
  output logic [INT_W-1:0] pendInt,
  output logic [MOD_W-1:0] pendSeed,
  output logic [INT_W-1:0] actInt,
  output logic [MOD_W-1:0] actFrac,
  output logic [MOD_W-1:0] actMod,
  output logic             fracErr
);
  localparam logic [MOD_W-1:0] LFSR_INIT = MOD_W'(12'hACE);

  logic             pendValid;
  logic [MOD_W-1:0] pendFrac, pendMod;
  logic [MOD_W-1:0] lfsrQ;
  logic [MOD_W-1:0] modEff, fracEff, seedEff;
  logic             badIn;

  // Input sanitising: zero modulus becomes 1, oversize fraction clamps
  always_comb begin
    modEff  = (modIn == '0) ? MOD_W'(1) : modIn;
    badIn   = (modIn == '0) || (fracIn >= modEff);
    fracEff = badIn ? (modEff - MOD_W'(1)) : fracIn;
    seedEff = ditherEn ? MOD_W'(lfsrQ % modEff) : '0;
  end

  // Free-running LFSR, x^12+x^6+x^4+x+1 taps
  always_ff @(posedge clk) begin
    if (!rstN) lfsrQ <= LFSR_INIT;
    else       lfsrQ <= {lfsrQ[MOD_W-2:0], lfsrQ[11] ^ lfsrQ[5] ^ lfsrQ[3] ^ lfsrQ[0]};
  end

  // Double buffer: capture on strobe, apply on the next tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendInt   <= '0;
      pendFrac  <= '0;
      pendMod   <= MOD_W'(1);
      pendSeed  <= '0;
      actInt    <= '0;
      actFrac   <= '0;
      actMod    <= MOD_W'(1);
      fracErr   <= 1'b0;
    end else begin
      if (pendValid) begin
        actInt  <= pendInt;
        actFrac <= pendFrac;
        actMod  <= pendMod;
      end
      pendValid <= loadStb;
      if (loadStb) begin
        pendInt  <= intIn;
        pendFrac <= fracEff;
        pendMod  <= modEff;
        pendSeed <= seedEff;
        fracErr  <= badIn;
      end
    end
  end

  always_comb begin
    strobe.applyNew = pendValid;
    strobe.stepAcc  = !pendValid;
  end

  // R6: invalid fraction at capture raises the flag
  a_r6_err_on_bad_frac: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && fracIn >= modIn) |=> fracErr);
  // R7: zero modulus is flagged
  a_r7_err_on_zero_mod: assert property (@(posedge clk) disable iff (!rstN)
    (loadStb && modIn == '0) |=> (fracErr && pendMod == MOD_W'(1)));
  // R6: active fraction is always below the active modulus
  a_r6_frac_clamped: assert property (@(posedge clk) disable iff (!rstN)
    actFrac < actMod);
  // R5: every strobe is followed by an apply tick
  a_r5_apply_after_load: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |=> strobe.applyNew);
  a_r5_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({strobe.applyNew, strobe.stepAcc}));
endmodule

// File: rtl/fracn_datapath.sv
module fracn_datapath
  import fracn_pkg::*;
#(
  parameter int INT_W = 16,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  fnStrobe_t        strobe,
  input  logic [INT_W-1:0] pendInt,
  input  logic [MOD_W-1:0] pendSeed,
  input  logic [INT_W-1:0] actInt,
  input  logic [MOD_W-1:0] actFrac,
  input  logic [MOD_W-1:0] actMod,
  output logic [INT_W:0]   divRatio
);
  localparam int SUM_W = MOD_W + 1;

  logic [MOD_W-1:0] accQ, accNext;
  logic [SUM_W-1:0] sumW;
  logic             wrap;

  // Modulo-M accumulate: add F, subtract M on overflow past M
  always_comb begin
    sumW    = {1'b0, accQ} + {1'b0, actFrac};
    wrap    = sumW >= {1'b0, actMod};
    accNext = wrap ? MOD_W'(sumW - {1'b0, actMod}) : sumW[MOD_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= '0;
      divRatio <= '0;
    end else if (strobe.applyNew) begin
      accQ     <= pendSeed;
      divRatio <= {1'b0, pendInt};
    end else if (strobe.stepAcc) begin
      accQ     <= accNext;
      divRatio <= {1'b0, actInt} + (INT_W+1)'(wrap);
    end
  end

  // R2: accumulator never reaches the modulus
  a_r2_acc_below_mod: assert property (@(posedge clk) disable iff (!rstN)
    accQ < actMod);
  // R2: output is N or N+1 of the active set
  a_r2_ratio_range: assert property (@(posedge clk) disable iff (!rstN)
    (divRatio == {1'b0, actInt}) || (divRatio == {1'b0, actInt} + 1'b1));
  // R10: zero fraction never adds one
  a_r10_zero_frac: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepAcc && actFrac == '0) |=> divRatio == {1'b0, $past(actInt)});
  // R5: apply tick outputs the new integer with no step
  a_r5_apply_outputs_int: assert property (@(posedge clk) disable iff (!rstN)
    strobe.applyNew |=> divRatio == {1'b0, $past(pendInt)});
endmodule

// File: rtl/fracn_ratio_ctrl.sv
module fracn_ratio_ctrl
  import fracn_pkg::*;
#(
  parameter int INT_W = 16,
  parameter int MOD_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStb,
  input  logic [INT_W-1:0] intIn,
  input  logic [MOD_W-1:0] fracIn,
  input  logic [MOD_W-1:0] modIn,
  input  logic             ditherEn,
  output logic [INT_W:0]   divRatio,
  output logic             fracErr
);
  fnStrobe_t        strobe;
  logic [INT_W-1:0] pendInt, actInt;
  logic [MOD_W-1:0] pendSeed, actFrac, actMod;

  fracn_ctrl #(.INT_W(INT_W), .MOD_W(MOD_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .intIn(intIn),
    .fracIn(fracIn), .modIn(modIn), .ditherEn(ditherEn),
    .strobe(strobe), .pendInt(pendInt), .pendSeed(pendSeed),
    .actInt(actInt), .actFrac(actFrac), .actMod(actMod), .fracErr(fracErr)
  );

  fracn_datapath #(.INT_W(INT_W), .MOD_W(MOD_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pendInt(pendInt),
    .pendSeed(pendSeed), .actInt(actInt), .actFrac(actFrac),
    .actMod(actMod), .divRatio(divRatio)
  );
endmodule

// File: tb/test_fracn_ratio_ctrl.sv
module test_fracn_ratio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int INT_W = 16;
  localparam int MOD_W = 12;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             loadStb = 1'b0;
  logic [INT_W-1:0] intIn = '0;
  logic [MOD_W-1:0] fracIn = '0;
  logic [MOD_W-1:0] modIn = '0;
  logic             ditherEn = 1'b0;
  logic [INT_W:0]   divRatio;
  logic             fracErr;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fracn_ratio_ctrl #(.INT_W(INT_W), .MOD_W(MOD_W)) i_fracn_ratio_ctrl (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .intIn(intIn),
    .fracIn(fracIn), .modIn(modIn), .ditherEn(ditherEn),
    .divRatio(divRatio), .fracErr(fracErr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Bench model of the expected step pattern (R4)
  function automatic bit expHigh(input longint k, input longint f, input longint m);
    return ((k * f) / m) != (((k - 1) * f) / m);
  endfunction

  function automatic longint effMod(input longint m);
    return (m == 0) ? 1 : m;
  endfunction

  function automatic longint effFrac(input longint f, input longint m);
    longint me = effMod(m);
    return (f >= me) ? me - 1 : f;
  endfunction

  // Run MOD step ticks after the apply tick and judge pattern and sum
  task automatic runWindow(input longint n, input longint f, input longint m,
                           input bit dith, input string tag);
    longint sum = 0;
    bit patOk = 1'b1;
    bit rngOk = 1'b1;
    longint badK = 0, badV = 0;
    for (longint k = 1; k <= m; k++) begin
      @(posedge clk);
      // R5: unrelated programming changes must not matter
      intIn  = INT_W'($urandom);
      fracIn = MOD_W'($urandom);
      modIn  = MOD_W'($urandom);
      @(negedge clk);
      sum += longint'(divRatio);
      if (divRatio != n && divRatio != n + 1) begin rngOk = 1'b0; badV = divRatio; end
      if (!dith && patOk && (longint'(divRatio) != n + longint'(expHigh(k, f, m)))) begin
        patOk = 1'b0; badK = k; badV = divRatio;
      end
    end
    chk(rngOk, {"R2 ratio range ", tag}, badV, n);
    chk(sum == m * n + f, {"R3 window sum ", tag}, sum, m * n + f);
    if (!dith) chk(patOk, {"R4 pattern ", tag}, badV, n + longint'(expHigh(badK, f, m)));
  endtask

  // One load: strobe, check flag, check apply tick, run a window
  task automatic doLoad(input longint n, input longint f, input longint m,
                        input bit dith, input string tag);
    longint me = effMod(m);
    longint fe = effFrac(f, m);
    bit expErr = (m == 0) || (f >= me);
    @(negedge clk);
    intIn = INT_W'(n); fracIn = MOD_W'(f); modIn = MOD_W'(m); ditherEn = dith;
    loadStb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    loadStb = 1'b0;
    ditherEn = ~dith;
    chk(fracErr == expErr, {"R6 R7 error flag ", tag}, fracErr, expErr);
    @(posedge clk);
    @(negedge clk);
    chk(divRatio == n, {"R5 apply tick ", tag}, divRatio, n);
    runWindow(n, fe, me, dith, tag);
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(divRatio == 0, "R1 reset ratio", divRatio, 0);
    chk(fracErr == 1'b0, "R1 reset flag", fracErr, 0);
    rstN = 1'b1;

    doLoad(138, 30, 65, 1'b0, "R11 138+30/65");
    doLoad(138, 60, 130, 1'b0, "R11 mod130");
    doLoad(200, 123, 520, 1'b0, "R11 mod520");
    doLoad(77, 4094, 4095, 1'b0, "R11 mod4095");
    doLoad(50, 0, 97, 1'b0, "R10 zero frac");
    doLoad(90, 1, 2, 1'b0, "R4 half");
    doLoad(33, 70, 65, 1'b0, "R6 clamp");
    doLoad(33, 5, 0, 1'b0, "R7 zero mod");
    doLoad(40, 10, 65, 1'b0, "R6 flag clears");
    doLoad(138, 30, 65, 1'b1, "R9 dither");
    doLoad(12, 517, 520, 1'b1, "R9 dither 520");

    // R8: strobes on two consecutive edges
    begin
      longint nA = 300, fA = 7, mA = 13;
      longint nB = 301, fB = 200, mB = 333;
      @(negedge clk);
      intIn = INT_W'(nA); fracIn = MOD_W'(fA); modIn = MOD_W'(mA); ditherEn = 1'b0;
      loadStb = 1'b1;
      @(posedge clk);
      @(negedge clk);
      intIn = INT_W'(nB); fracIn = MOD_W'(fB); modIn = MOD_W'(mB);
      @(posedge clk);
      @(negedge clk);
      loadStb = 1'b0;
      chk(divRatio == nA, "R8 first set applied", divRatio, nA);
      chk(fracErr == 1'b0, "R8 flag after overlap", fracErr, 0);
      @(posedge clk);
      @(negedge clk);
      chk(divRatio == nB, "R8 second set applied", divRatio, nB);
      runWindow(nB, fB, mB, 1'b0, "R8 second window");
    end

    // Constrained random loads, occasionally invalid or dithered
    for (int i = 0; i < 14; i++) begin
      longint m = longint'($urandom_range(1, 600));
      longint f = longint'($urandom_range(0, 32'(m + 3)));
      longint n = longint'($urandom_range(1, 65534));
      bit d = ($urandom_range(0, 3) == 0);
      doLoad(n, f, m, d, "R3 random");
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule